// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer reached through a small 32-bit register bus. Software enables it, picks two power-of-two timeout spans and picks one of two behaviours. In the direct behaviour, letting the counter run out requests a system reset. In the staged behaviour, the first run-out raises an interrupt and starts a second countdown. If the interrupt is still pending when that second countdown ends, a reset is requested.

Software keeps the watchdog alive by writing a fixed key to a restart register. That write reloads the first span and drops any pending interrupt. An interrupt handler can acknowledge the interrupt without restarting the counter by reading a clear register.

The block drives a one-cycle reset-request pulse and a level interrupt. Producing the actual system reset, gating the clock and wiring the interrupt are left to the surrounding chip.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, every register reads 0: control at 0x00, spans at 0x04, counter at 0x08, status at 0x10. Both `irq` and `rst_req` are low.
- R2: Control bit 0 is enable. A write that sets it while it is clear loads the counter with 2^(8+A)-1, where A is span register bits [7:4]. The counter then falls by 1 on every clock edge at which enable was already set.
- R3: With control bit 1 clear, the edge after the counter reads 0 raises `rst_req` for exactly one cycle. On that same edge every register returns to its reset value.
- R4: With control bit 1 set and no interrupt pending, the edge after the counter reads 0 sets `irq` and status bit 0. On that edge the counter loads 2^(8+B)-1, where B is span register bits [3:0].
- R5: With control bit 1 set, if the counter expires while the interrupt is still pending, `rst_req` pulses as in R3.
- R6: If the interrupt was cleared during the second countdown, expiry raises it again and reloads 2^(8+B)-1 with no reset request.
- R7: Writing exactly 0x76 to 0x0C reloads 2^(8+A)-1 and clears the pending interrupt. Writing any other value there changes nothing.
- R8: A read of 0x14 returns 0 and clears the pending interrupt on that edge. It does not reload the counter.
- R9: A write to the span register is visible on read at once, but the running countdown only uses it at the next load.
- R10: While enable is clear, the counter holds its value and neither `irq` nor `rst_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_re | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Pending watchdog interrupt, level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong counter or load value shows first through the counter register. It also shifts the `irq` or `rst_req` edge by a number of cycles equal to the error. For this reason, every expiry is checked on the exact edge, together with the cycle just before it. A wrong pending flag shows at the second expiry: there is an early or missing reset pulse, or a missing re-raise of `irq`, up to one second span later. A leftover register value after a reset request shows on the very next read of control or spans.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int MIN_EXP = 8,
  parameter int IDX_W   = 4,
  parameter logic [DW-1:0] KEY = 32'h76
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          rst_req
);
  localparam int CW = MIN_EXP + (1 << IDX_W) - 1;
  localparam logic [AW-1:0] A_CTL  = AW'(5'h00);
  localparam logic [AW-1:0] A_SPAN = AW'(5'h04);
  localparam logic [AW-1:0] A_CNT  = AW'(5'h08);
  localparam logic [AW-1:0] A_KICK = AW'(5'h0C);
  localparam logic [AW-1:0] A_STAT = AW'(5'h10);
  localparam logic [AW-1:0] A_CLR  = AW'(5'h14);

  logic             en_q, mode_q, irq_q, rst_req_q;
  logic [IDX_W-1:0] span_a_q, span_b_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [CW-1:0] span(input logic [IDX_W-1:0] idx);
    return (CW'(1) << (MIN_EXP + int'(idx))) - CW'(1);
  endfunction

  wire wr_ctl  = bus_we && bus_addr == A_CTL;
  wire wr_span = bus_we && bus_addr == A_SPAN;
  wire kick    = bus_we && bus_addr == A_KICK && bus_wdata == KEY;
  wire rd_clr  = bus_re && bus_addr == A_CLR;
  wire start   = wr_ctl && bus_wdata[0] && !en_q;
  wire expire  = en_q && cnt_q == '0;
  wire fatal   = expire && !kick && (!mode_q || (irq_q && !rd_clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= fatal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= 1'b0; irq_q <= 1'b0;
      span_a_q <= '0; span_b_q <= '0; cnt_q <= '0;
    end else if (fatal) begin
      en_q <= 1'b0; mode_q <= 1'b0; irq_q <= 1'b0;
      span_a_q <= '0; span_b_q <= '0; cnt_q <= '0;
    end else begin
      if (wr_ctl) {mode_q, en_q} <= bus_wdata[1:0];
      if (wr_span) {span_a_q, span_b_q} <= bus_wdata[2*IDX_W-1:0];
      if (kick)        irq_q <= 1'b0;
      else if (expire) irq_q <= 1'b1;
      else if (rd_clr) irq_q <= 1'b0;
      if (kick || start) cnt_q <= span(span_a_q);
      else if (expire)   cnt_q <= span(span_b_q);
      else if (en_q)     cnt_q <= cnt_q - CW'(1);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:  bus_rdata = DW'({mode_q, en_q});
      A_SPAN: bus_rdata = DW'({span_a_q, span_b_q});
      A_CNT:  bus_rdata = DW'(cnt_q);
      A_STAT: bus_rdata = DW'(irq_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = irq_q;
  assign rst_req = rst_req_q;

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  assert_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> (!en_q && !irq_q && cnt_q == '0 && span_a_q == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !kick && !start) |=> $stable(cnt_q));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !irq_q) |=> (!irq_q && !rst_req_q));
  assert_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!irq_q && cnt_q == span($past(span_a_q))));
  assert_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (mode_q && cnt_q == span(span_b_q)));
endmodule

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  wdog_two_stage dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req));

  function automatic int span(input int i);
    return (1 << (8 + i)) - 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic clr(output logic [31:0] d);
    bus_addr = 5'h14; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_case(input int a, input int b, input bit mode, input bit do_clr);
    logic [31:0] v;
    wr(5'h04, 32'(a * 16 + b));
    wr(5'h00, {30'b0, mode, 1'b1});
    rd(5'h08, v); chk("R2 load", v, 32'(span(a)));
    wait_n(span(a));
    rd(5'h08, v); chk("R2 count to zero", v, 0);
    chk("R3 no early request", 32'(rst_req), 0);
    wait_n(1);
    if (!mode) begin
      chk("R3 request pulse", 32'(rst_req), 1);
      rd(5'h00, v); chk("R3 control cleared", v, 0);
      rd(5'h04, v); chk("R3 spans cleared", v, 0);
      wait_n(1);
      chk("R3 single cycle", 32'(rst_req), 0);
    end else begin
      chk("R4 irq raised", 32'(irq), 1);
      rd(5'h10, v); chk("R4 status bit", v, 1);
      rd(5'h08, v); chk("R4 second span", v, 32'(span(b)));
      if (do_clr) begin
        clr(v); chk("R8 read data", v, 0);
        chk("R8 irq cleared", 32'(irq), 0);
        rd(5'h08, v); chk("R8 no reload", v, 32'(span(b) - 1));
        wait_n(span(b));
        chk("R6 irq again", 32'(irq), 1);
        chk("R6 no request", 32'(rst_req), 0);
        rd(5'h08, v); chk("R6 reload", v, 32'(span(b)));
      end
      wait_n(span(b));
      chk("R5 no early request", 32'(rst_req), 0);
      wait_n(1);
      chk("R5 request pulse", 32'(rst_req), 1);
      chk("R5 irq cleared by request", 32'(irq), 0);
      wait_n(1);
      chk("R5 single cycle", 32'(rst_req), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'h5eed);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    rd(5'h00, v); chk("R1 control", v, 0);
    rd(5'h04, v); chk("R1 spans", v, 0);
    rd(5'h08, v); chk("R1 counter", v, 0);
    rd(5'h10, v); chk("R1 status", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rst_req", 32'(rst_req), 0);

    wr(5'h04, 32'h20);
    wr(5'h00, 32'h1);
    rd(5'h08, v); chk("R2 load", v, 1023);
    wait_n(5);
    rd(5'h08, v); chk("R2 decrement", v, 1018);
    wr(5'h00, 32'h0);
    rd(5'h08, v); chk("R10 last decrement", v, 1017);
    wait_n(300);
    rd(5'h08, v); chk("R10 hold", v, 1017);
    chk("R10 no irq", 32'(irq), 0);
    chk("R10 no request", 32'(rst_req), 0);

    wr(5'h04, 32'h00);
    wr(5'h00, 32'h1);
    rd(5'h08, v); chk("R2 load new span", v, 255);
    wr(5'h04, 32'h10);
    rd(5'h04, v); chk("R9 readback", v, 32'h10);
    rd(5'h08, v); chk("R9 count unaffected", v, 254);
    wr(5'h0C, 32'h75);
    rd(5'h08, v); chk("R7 wrong key ignored", v, 253);
    wr(5'h0C, 32'h76);
    rd(5'h08, v); chk("R9 new span at load", v, 511);
    wr(5'h00, 32'h0);

    wr(5'h04, 32'h00);
    wr(5'h00, 32'h3);
    wait_n(256);
    chk("R4 irq raised", 32'(irq), 1);
    wr(5'h0C, 32'h11);
    chk("R7 wrong key keeps irq", 32'(irq), 1);
    wr(5'h0C, 32'h76);
    chk("R7 key clears irq", 32'(irq), 0);
    rd(5'h08, v); chk("R7 key reload", v, 255);
    chk("R7 no request", 32'(rst_req), 0);
    wr(5'h00, 32'h0);

    run_case(0, 0, 1'b0, 1'b0);
    run_case(1, 0, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      int a, b;
      bit m, c;
      a = int'($urandom % 3);
      b = int'($urandom % 3);
      m = 1'($urandom);
      c = 1'($urandom);
      run_case(a, b, m, c);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule